// File: doc/BRIEF.md
# Boundary Test Register with Signature, Pattern and Count Modes

This block is a test-data register that sits on the I/O boundary of a bus device and runs entirely on the test clock. Each of the N device pins has two cells: an observe cell, which samples what arrives at the pin, and a control cell, which holds the value to force onto the pin. The control cells feed an update stage. While the test-mode input is high, the update stage drives the pin outputs. While it is low, the functional outputs pass straight through and register activity has no effect on them.

The TAP controller and the instruction register are outside the block. Their decoded results arrive as a capture strobe, a shift strobe, an update strobe, a run strobe and a two-bit operation code. The run strobe advances the chosen engine:

- a signature compressor that folds the pin inputs into the observe cells;
- a pseudo-random pattern generator on the control cells;
- a combined mode that compresses the inputs while the control cells count up in binary, for addressing a memory under test.

Top module: `boundary_test_reg`

## Requirements
- R1: While trst_n is low, every observe, control and update cell is zero and tdo_o is zero.
- R2: With test_mode_i low, pin_out_o equals func_out_i in every cycle, whatever the strobes do.
- R3: With test_mode_i high, pin_out_o equals the update stage.
- R4: On a rising tck with capture_i high, the observe cells load pin_in_i and the control cells load the pin_out_o value present before that edge. Capture has priority over shift and run.
- R5: On a rising tck with shift_i high and capture_i low, the 2N cells shift one place as a single chain. tdi_i enters control bit N-1. Control bit 0 moves into observe bit N-1. Observe bit 0 leaves the chain. Shift has priority over run.
- R6: tdo_o changes only on the falling tck edge, and there takes the value of observe bit 0.
- R7: The update stage loads the control cells only on a rising tck with update_i high. When update_i and shift_i are high in the same cycle, it takes the control value from before the shift. Otherwise it holds, except as set out in R9 and R10.
- R8: With run_i high, neither capture_i nor shift_i high, and op_i = 1 (signature), the observe cells become step(obs) XOR pin_in_i. step(x) = {x[N-2:0], x[N-1] ^ x[TAP-1]}, with N=18 and TAP=11 by default.
- R9: Under the same conditions with op_i = 2 (pattern), the control cells become step(ctl). The update stage takes the same new value unless update_i is high.
- R10: Under the same conditions with op_i = 3 (signature plus count), the observe cells advance as in R8. The control cells become ctl+1 modulo 2^N, wrapping from all ones to zero, and the update stage follows unless update_i is high.
- R11: With op_i = 0 (plain boundary), run_i has no effect on any cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| test_mode_i | input | 1 | 1 = pins are driven from the update stage |
| op_i | input | 2 | Decoded operation: 0 boundary, 1 signature, 2 pattern, 3 signature+count |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| run_i | input | 1 | Run strobe that advances the selected engine |
| tdi_i | input | 1 | Serial test data in |
| pin_in_i | input | N | Data arriving at the pins |
| func_out_i | input | N | Functional output values from the core |
| pin_out_o | output | N | Values driven onto the pins |
| tdo_o | output | 1 | Serial test data out |

## Verification
Several pairs of strobes can land on the same rising edge, and these are the cases most likely to go wrong:

- update with shift, where the update stage must take the control value from before the shift;
- update with a pattern or count step, where the strobe wins over the engine's own load;
- capture with shift or run, where only the capture acts.

The bench provokes each pair directly and also through weighted random strobes. It judges each result by comparing pin_out_o, and the bits scanned out on tdo_o, against a reference model built from the priorities above.

// File: rtl/btr_pkg.sv
package btr_pkg;

    typedef enum logic [1:0] {
        OP_BOUNDARY  = 2'd0,
        OP_SIGNATURE = 2'd1,
        OP_PATTERN   = 2'd2,
        OP_SIG_COUNT = 2'd3
    } btr_op_e;

endpackage

// File: rtl/btr_advance.sv
module btr_advance #(
    parameter int W       = 18,
    parameter int TAP     = 11,
    parameter bit COUNTER = 1'b0
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    generate
        if (COUNTER) begin : g_count
            assign nxt_o = cur_i + {{(W-1){1'b0}}, 1'b1};
        end else begin : g_lfsr
            assign nxt_o = {cur_i[W-2:0], cur_i[W-1] ^ cur_i[TAP-1]};
        end
    endgenerate
endmodule

// File: rtl/btr_pin_mux.sv
module btr_pin_mux #(
    parameter int W = 18
) (
    input  logic         test_mode_i,
    input  logic [W-1:0] upd_i,
    input  logic [W-1:0] func_i,
    output logic [W-1:0] pin_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pin_o[b] = test_mode_i ? upd_i[b] : func_i[b];
    end
endmodule

// File: rtl/btr_tdo_stage.sv
module btr_tdo_stage (
    input  logic tck,
    input  logic trst_n,
    input  logic bit_i,
    output logic tdo_o
);
    logic tdo_d, tdo_q;

    always_comb tdo_d = bit_i;

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo_o = tdo_q;
endmodule

// File: rtl/boundary_test_reg.sv
module boundary_test_reg
    import btr_pkg::*;
#(
    parameter int N   = 18,
    parameter int TAP = 11
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         test_mode_i,
    input  logic [1:0]   op_i,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic         update_i,
    input  logic         run_i,
    input  logic         tdi_i,
    input  logic [N-1:0] pin_in_i,
    input  logic [N-1:0] func_out_i,
    output logic [N-1:0] pin_out_o,
    output logic         tdo_o
);
    localparam int CHAIN = 2 * N;

    typedef struct packed {
        logic [N-1:0] obs;
        logic [N-1:0] ctl;
        logic [N-1:0] upd;
    } btr_state_t;

    btr_state_t st_d, st_q;
    btr_op_e    op;
    logic [N-1:0] sig_nxt, pat_nxt, cnt_nxt;
    logic [CHAIN-1:0] chain_nxt;
    logic         engine_act;

    assign op = btr_op_e'(op_i);

    btr_advance #(.W(N), .TAP(TAP), .COUNTER(1'b0)) i_sig (.cur_i(st_q.obs), .nxt_o(sig_nxt));
    btr_advance #(.W(N), .TAP(TAP), .COUNTER(1'b0)) i_pat (.cur_i(st_q.ctl), .nxt_o(pat_nxt));
    btr_advance #(.W(N), .TAP(TAP), .COUNTER(1'b1)) i_cnt (.cur_i(st_q.ctl), .nxt_o(cnt_nxt));

    btr_pin_mux #(.W(N)) i_mux (
        .test_mode_i (test_mode_i),
        .upd_i       (st_q.upd),
        .func_i      (func_out_i),
        .pin_o       (pin_out_o)
    );

    btr_tdo_stage i_tdo (
        .tck    (tck),
        .trst_n (trst_n),
        .bit_i  (st_q.obs[0]),
        .tdo_o  (tdo_o)
    );

    assign chain_nxt  = {tdi_i, st_q.ctl, st_q.obs[N-1:1]};
    assign engine_act = run_i && !capture_i && !shift_i;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.obs = pin_in_i;
            st_d.ctl = pin_out_o;
        end else if (shift_i) begin
            st_d.ctl = chain_nxt[CHAIN-1:N];
            st_d.obs = chain_nxt[N-1:0];
        end else if (run_i) begin
            case (op)
                OP_SIGNATURE: st_d.obs = sig_nxt ^ pin_in_i;
                OP_PATTERN:   st_d.ctl = pat_nxt;
                OP_SIG_COUNT: begin
                    st_d.obs = sig_nxt ^ pin_in_i;
                    st_d.ctl = cnt_nxt;
                end
                default: ;
            endcase
        end
        if (update_i) begin
            st_d.upd = st_q.ctl;
        end else if (engine_act && (op == OP_PATTERN || op == OP_SIG_COUNT)) begin
            st_d.upd = st_d.ctl;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_CAPTURE_OBS: assert property (@(posedge tck) disable iff (!trst_n)
        capture_i |=> st_q.obs == $past(pin_in_i)); // R4

    AST_SHIFT_IN: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_i && !capture_i) |=> st_q.ctl[N-1] == $past(tdi_i)); // R5

    AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (!update_i && !(engine_act && op_i[1])) |=> $stable(st_q.upd)); // R7

    AST_COUNT_STEP: assert property (@(posedge tck) disable iff (!trst_n)
        (engine_act && op == OP_SIG_COUNT) |=> st_q.ctl == $past(st_q.ctl) + 1'b1); // R10

    AST_IDLE_RUN: assert property (@(posedge tck) disable iff (!trst_n)
        (engine_act && op == OP_BOUNDARY) |=> ($stable(st_q.obs) && $stable(st_q.ctl))); // R11

    AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (!trst_n)
        !test_mode_i |-> pin_out_o == func_out_i); // R2
endmodule

// File: tb/test_boundary_test_reg.sv
module test_boundary_test_reg;
    localparam int N = 18;
    localparam int TAP = 11;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tm = 1'b0, cap = 1'b0, sh = 1'b0, up = 1'b0, run = 1'b0, tdi = 1'b0;
    logic [1:0] op = 2'd0;
    logic [N-1:0] pin_in = '0, func = '0;
    logic [N-1:0] pin_out;
    logic tdo;

    logic [N-1:0] m_obs = '0, m_ctl = '0, m_upd = '0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 tck = ~tck;

    boundary_test_reg #(.N(N), .TAP(TAP)) i_boundary_test_reg (
        .tck(tck), .trst_n(trst_n), .test_mode_i(tm), .op_i(op),
        .capture_i(cap), .shift_i(sh), .update_i(up), .run_i(run),
        .tdi_i(tdi), .pin_in_i(pin_in), .func_out_i(func),
        .pin_out_o(pin_out), .tdo_o(tdo)
    );

    function automatic logic [N-1:0] lf(input logic [N-1:0] x);
        return {x[N-2:0], x[N-1] ^ x[TAP-1]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        cap = 0; sh = 0; up = 0; run = 0;
    endtask

    task automatic tick();
        logic [N-1:0] mpin, n_obs, n_ctl, n_upd;
        logic [2*N-1:0] ch;
        mpin = tm ? m_upd : func;
        n_obs = m_obs; n_ctl = m_ctl; n_upd = m_upd;
        if (cap) begin
            n_obs = pin_in; n_ctl = mpin;
        end else if (sh) begin
            ch = {tdi, m_ctl, m_obs[N-1:1]};
            n_ctl = ch[2*N-1:N]; n_obs = ch[N-1:0];
        end else if (run) begin
            case (op)
                2'd1: n_obs = lf(m_obs) ^ pin_in;
                2'd2: n_ctl = lf(m_ctl);
                2'd3: begin n_obs = lf(m_obs) ^ pin_in; n_ctl = m_ctl + 1'b1; end
                default: ;
            endcase
        end
        if (up) n_upd = m_ctl;
        else if (run && !cap && !sh && op[1]) n_upd = n_ctl;
        @(posedge tck);
        #1;
        chk(tdo === m_obs[0], "R6 tdo before falling edge", 64'(tdo), 64'(m_obs[0]));
        m_obs = n_obs; m_ctl = n_ctl; m_upd = n_upd;
        @(negedge tck);
        #1;
        chk(tdo === m_obs[0], "R6 tdo", 64'(tdo), 64'(m_obs[0]));
        if (tm) chk(pin_out === m_upd, "R3 pin from update", 64'(pin_out), 64'(m_upd));
        else    chk(pin_out === func,  "R2 functional pass", 64'(pin_out), 64'(func));
    endtask

    task automatic load_ctl(input logic [N-1:0] v);
        clear_strobes();
        sh = 1;
        for (int i = 0; i < 2 * N; i++) begin
            tdi = (i < N) ? 1'b0 : v[i - N];
            tick();
        end
        sh = 0; tdi = 0;
    endtask

    task automatic scan_out(output logic [2*N-1:0] got);
        clear_strobes();
        sh = 1; tdi = 0;
        for (int i = 0; i < 2 * N; i++) begin
            got[i] = tdo;
            tick();
        end
        sh = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] got;
        logic [N-1:0] seed, exp, sig;
        void'($urandom(32'd2024));

        #23;
        chk(tdo === 1'b0, "R1 tdo in reset", 64'(tdo), 0);
        tm = 1; #1;
        chk(pin_out === '0, "R1 update stage in reset", 64'(pin_out), 0);
        @(negedge tck); #1;
        trst_n = 1;

        // R4: capture pins then read the chain serially
        pin_in = 18'h2B5C3; func = 18'h1A0F0; tm = 0;
        clear_strobes(); cap = 1; tick();
        scan_out(got);
        chk(got === {18'h1A0F0, 18'h2B5C3}, "R4 capture obs and ctl", 64'(got), 64'({18'h1A0F0, 18'h2B5C3}));

        // R5 + R7: load control cells, update, force in test mode
        tm = 1;
        load_ctl(18'h3C3A5);
        chk(pin_out === '0, "R7 no update during shift", 64'(pin_out), 0);
        clear_strobes(); up = 1; tick(); up = 0;
        chk(pin_out === 18'h3C3A5, "R5 shifted value updated", 64'(pin_out), 64'(18'h3C3A5));

        // R7: shift and update in the same cycle use pre-shift ctl
        load_ctl(18'h00F0F);
        clear_strobes(); sh = 1; up = 1; tdi = 1; tick();
        chk(pin_out === 18'h00F0F, "R7 update with shift", 64'(pin_out), 64'(18'h00F0F));
        clear_strobes(); tdi = 0;

        // R9: pattern sequence against reference LFSR
        seed = 18'h12345;
        load_ctl(seed);
        exp = seed;
        clear_strobes(); op = 2'd2; run = 1;
        for (int k = 0; k < 40; k++) begin
            tick();
            exp = lf(exp);
            chk(pin_out === exp, "R9 pattern step", 64'(pin_out), 64'(exp));
        end
        // R9: update strobe wins against the pattern load
        up = 1; tick(); up = 0;
        chk(pin_out === exp, "R9 update beats pattern", 64'(pin_out), 64'(exp));
        exp = lf(exp);
        run = 0;

        // R10: count wraps from all ones
        load_ctl('1);
        clear_strobes(); op = 2'd3; run = 1; tick();
        chk(pin_out === '0, "R10 count wrap", 64'(pin_out), 0);
        tick();
        chk(pin_out === 18'd1, "R10 count step", 64'(pin_out), 1);
        run = 0;

        // R8: signature over a directed input stream from zero obs
        pin_in = '0; clear_strobes(); cap = 1; tick(); cap = 0;
        sig = '0; op = 2'd1; run = 1;
        for (int k = 0; k < 25; k++) begin
            pin_in = N'(k * 32'h9E37 + 5);
            sig = lf(sig) ^ pin_in;
            tick();
        end
        run = 0;
        scan_out(got);
        chk(got[N-1:0] === sig, "R8 signature", 64'(got[N-1:0]), 64'(sig));

        // R11: run in boundary op leaves cells alone
        pin_in = 18'h15555; clear_strobes(); cap = 1; tick(); cap = 0;
        op = 2'd0; run = 1;
        for (int k = 0; k < 5; k++) tick();
        run = 0;
        scan_out(got);
        chk(got[N-1:0] === 18'h15555, "R11 boundary run ignored", 64'(got[N-1:0]), 64'(18'h15555));

        // R4: capture beats shift and run in the same cycle
        pin_in = 18'h0ABCD; clear_strobes(); cap = 1; sh = 1; run = 1; op = 2'd3; tick();
        clear_strobes();
        chk(tdo === 1'b1, "R4 capture priority", 64'(tdo), 1);

        // random mix
        for (int k = 0; k < 1500; k++) begin
            cap = ($urandom_range(9) == 0);
            sh  = ($urandom_range(2) == 0);
            up  = ($urandom_range(5) == 0);
            run = ($urandom_range(2) == 0);
            op  = 2'($urandom_range(3));
            tdi = 1'($urandom);
            tm  = ($urandom_range(4) != 0);
            pin_in = N'($urandom);
            func   = N'($urandom);
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule